// File: doc/BRIEF.md
# Dual-Clock FIFO Reset Qualifier

This block sits at the front of a two-clock FIFO and decides whether a reset request was long enough to count. The request is an asynchronous active-low pin. It is synchronized into each port clock domain. Each domain counts its own clock edges while its synchronized copy of the request is low. A reset counts as valid only when both domains have counted enough edges. Each domain tells the other that it has reached the minimum through a second synchronizer.

While reset is in progress, and after a request that was too short, the block drives the conservative starting values of the six FIFO status flags. All flags are active low. Full, empty and almost-empty are asserted. Almost-full and both mailbox flags are deasserted. After a qualified release, each domain raises its own done output and the full flag is withdrawn, so writes can begin. If the request was too short, an incomplete-reset output is raised in clock domain A, and the flags stay at their reset values until a proper reset occurs.

The rising edge of the reset pin itself captures a 2-bit code that selects the almost-full and almost-empty offsets. The code is held until the next rising edge of the pin.

Top module: `fifo_rst_ctrl`

## Requirements
- R1: Within three clock edges of a domain after the reset pin falls, that domain's done output is low. The incomplete-reset output is low while reset is held.
- R2: While reset is held, the flags have these values: init_full_n=0, init_empty_n=0, init_aempty_n=0, init_afull_n=1, init_mbox1_n=1 and init_mbox2_n=1.
- R3: A domain counts an edge when its synchronized copy of the reset request is low. If both domains counted at least MIN_EDGES (4) such edges, each domain's done output is high within SYNC_STAGES+1 (3) edges of its own clock after the pin rises, and rst_incomplete stays low.
- R4: After a qualified release, init_full_n goes high together with done_a.
- R5: If clock domain B counts fewer than MIN_EDGES edges, both done outputs stay low after release, rst_incomplete goes high and init_full_n stays low.
- R6: If clock domain A counts fewer than MIN_EDGES edges, both done outputs stay low after release and rst_incomplete goes high.
- R7: offset_code takes the value of offset_sel at the rising edge of rst_req_n. Later changes on offset_sel have no effect until the next rising edge.
- R8: A new reset of full length clears rst_incomplete while reset is held. Its release then completes normally.
- R9: init_afull_n, init_mbox1_n, init_mbox2_n, init_empty_n and init_aempty_n keep their reset values after release. The flag logic outside this block takes over from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_req_n | input | 1 | Asynchronous active-low reset request |
| offset_sel | input | 2 | Offset select code, captured when rst_req_n rises |
| done_a | output | 1 | Qualified reset complete, clk_a domain |
| done_b | output | 1 | Qualified reset complete, clk_b domain |
| rst_incomplete | output | 1 | Last reset was too short, clk_a domain |
| offset_code | output | 2 | Latched offset select code |
| init_full_n | output | 1 | Full flag initial value, active low |
| init_afull_n | output | 1 | Almost-full flag initial value, active low |
| init_mbox1_n | output | 1 | Mailbox 1 flag initial value, active low |
| init_empty_n | output | 1 | Empty flag initial value, active low |
| init_aempty_n | output | 1 | Almost-empty flag initial value, active low |
| init_mbox2_n | output | 1 | Mailbox 2 flag initial value, active low |

## Verification
A change on the reset pin reaches a domain after two of that domain's edges. The done and incomplete outputs then follow one edge later, so they are due three edges after the pin changes. The offset code follows the pin rise at once. The bench waits at least six edges of each affected clock before it samples, and it samples one nanosecond after an edge. Short resets are produced by stopping one clock after three edges, so the number of edges that domain counts is known exactly, while the other domain counts well beyond the minimum.

// File: rtl/fifo_rst_ctrl.sv
`timescale 1ns/1ps
module fifo_rst_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3,
  parameter int MIN_EDGES   = 4
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst_req_n,
  input  logic [1:0] offset_sel,
  output logic       done_a,
  output logic       done_b,
  output logic       rst_incomplete,
  output logic [1:0] offset_code,
  output logic       init_full_n,
  output logic       init_afull_n,
  output logic       init_mbox1_n,
  output logic       init_empty_n,
  output logic       init_aempty_n,
  output logic       init_mbox2_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_EDGES);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]     pin_a, pin_b, peer_a, peer_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic             arm_a, arm_b;
  logic             hold_a, hold_b, rel_a, rel_b, qual_a, qual_b;

  assign hold_a = ~pin_a[TOP];
  assign hold_b = ~pin_b[TOP];
  assign rel_a  = ~hold_a && (cnt_a != '0);
  assign rel_b  = ~hold_b && (cnt_b != '0);
  assign qual_a = (cnt_a >= CNT_MIN) && peer_a[TOP];
  assign qual_b = (cnt_b >= CNT_MIN) && peer_b[TOP];

  always_ff @(posedge clk_a) begin
    pin_a  <= {pin_a[TOP-1:0], rst_req_n};
    peer_a <= {peer_a[TOP-1:0], arm_b};
    if (!hold_a)                cnt_a <= '0;
    else if (cnt_a != CNT_MAX)  cnt_a <= cnt_a + 1'b1;
    if (hold_a && cnt_a == '0)  arm_a <= 1'b0;
    else if (cnt_a >= CNT_MIN)  arm_a <= 1'b1;
    if (hold_a) begin
      done_a         <= 1'b0;
      rst_incomplete <= 1'b0;
    end else if (rel_a) begin
      done_a         <= qual_a;
      rst_incomplete <= ~qual_a;
    end
  end

  always_ff @(posedge clk_b) begin
    pin_b  <= {pin_b[TOP-1:0], rst_req_n};
    peer_b <= {peer_b[TOP-1:0], arm_a};
    if (!hold_b)                cnt_b <= '0;
    else if (cnt_b != CNT_MAX)  cnt_b <= cnt_b + 1'b1;
    if (hold_b && cnt_b == '0)  arm_b <= 1'b0;
    else if (cnt_b >= CNT_MIN)  arm_b <= 1'b1;
    if (hold_b)     done_b <= 1'b0;
    else if (rel_b) done_b <= qual_b;
  end

  always_ff @(posedge rst_req_n) offset_code <= offset_sel;

  assign init_full_n   = done_a;
  assign init_afull_n  = 1'b1;
  assign init_mbox1_n  = 1'b1;
  assign init_empty_n  = 1'b0;
  assign init_aempty_n = 1'b0;
  assign init_mbox2_n  = 1'b1;
endmodule

// File: rtl/fifo_rst_ctrl_chk.sv
`timescale 1ns/1ps
module fifo_rst_ctrl_chk #(
  parameter int CNT_W     = 3,
  parameter int MIN_EDGES = 4
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_req_n,
  input logic             hold_a,
  input logic             hold_b,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic             done_a,
  input logic             done_b,
  input logic             rst_incomplete,
  input logic             init_full_n,
  input logic [1:0]       offset_code
);
  assert_done_a_clear_R1: assert property (@(posedge clk_a) disable iff (!rst_req_n)
    hold_a |=> !done_a);
  assert_done_b_clear_R1: assert property (@(posedge clk_b) disable iff (!rst_req_n)
    hold_b |=> !done_b);
  assert_done_a_edges_R3: assert property (@(posedge clk_a) disable iff (!rst_req_n)
    $rose(done_a) |-> ($past(cnt_a) >= CNT_W'(MIN_EDGES)));
  assert_done_b_edges_R3: assert property (@(posedge clk_b) disable iff (!rst_req_n)
    $rose(done_b) |-> ($past(cnt_b) >= CNT_W'(MIN_EDGES)));
  assert_full_blocked_R5: assert property (@(posedge clk_a) disable iff (!rst_req_n)
    rst_incomplete |-> (!init_full_n && !done_a));
  assert_offset_held_R7: assert property (@(posedge clk_a) disable iff (!rst_req_n)
    $past(rst_req_n) |-> $stable(offset_code));
endmodule

bind fifo_rst_ctrl fifo_rst_ctrl_chk #(.CNT_W(CNT_W), .MIN_EDGES(MIN_EDGES)) chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_req_n(rst_req_n),
  .hold_a(hold_a), .hold_b(hold_b), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .done_a(done_a), .done_b(done_b), .rst_incomplete(rst_incomplete),
  .init_full_n(init_full_n), .offset_code(offset_code)
);

// File: tb/fifo_rst_ctrl_test.sv
`timescale 1ns/1ps
module fifo_rst_ctrl_test;
  logic clk_a = 1'b0, clk_b = 1'b0, en_a = 1'b1, en_b = 1'b1;
  logic rst_req_n = 1'b0;
  logic [1:0] offset_sel = 2'b00;
  logic done_a, done_b, rst_incomplete;
  logic [1:0] offset_code;
  logic init_full_n, init_afull_n, init_mbox1_n, init_empty_n, init_aempty_n, init_mbox2_n;
  int checks = 0, errors = 0;

  always #2.5 clk_a = en_a ? ~clk_a : 1'b0;
  always #4   clk_b = en_b ? ~clk_b : 1'b0;

  fifo_rst_ctrl uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_req_n(rst_req_n), .offset_sel(offset_sel),
    .done_a(done_a), .done_b(done_b), .rst_incomplete(rst_incomplete),
    .offset_code(offset_code), .init_full_n(init_full_n), .init_afull_n(init_afull_n),
    .init_mbox1_n(init_mbox1_n), .init_empty_n(init_empty_n),
    .init_aempty_n(init_aempty_n), .init_mbox2_n(init_mbox2_n)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(posedge clk_a);
    #1;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  task automatic check_flags(input string req);
    check({req, " full_n"},   {3'b0, init_full_n},   4'b0);
    check({req, " others"},   {init_afull_n, init_mbox1_n, init_mbox2_n, 1'b0}, 4'b1110);
    check({req, " empties"},  {2'b0, init_empty_n, init_aempty_n}, 4'b0000);
  endtask

  task automatic test_hold_state;
    rst_req_n = 1'b0;
    wait_a(20);
    wait_b(4);
    check("R1 done_a/done_b/incomplete", {1'b0, done_a, done_b, rst_incomplete}, 4'b0000);
    check_flags("R2");
  endtask

  task automatic test_good_release(input logic [1:0] sel);
    offset_sel = sel;
    #1;
    rst_req_n = 1'b1;
    #1;
    offset_sel = ~sel;
    wait_a(6);
    wait_b(6);
    check("R3 done_a/done_b/incomplete", {1'b0, done_a, done_b, rst_incomplete}, 4'b0110);
    check("R4 full_n", {3'b0, init_full_n}, 4'b0001);
    check("R7 offset_code", {2'b0, offset_code}, {2'b0, sel});
    check("R9 afull/mbox1/mbox2", {1'b0, init_afull_n, init_mbox1_n, init_mbox2_n}, 4'b0111);
    check("R9 empty/aempty", {2'b0, init_empty_n, init_aempty_n}, 4'b0000);
    offset_sel = sel ^ 2'b01;
    wait_a(5);
    check("R7 offset ignored", {2'b0, offset_code}, {2'b0, sel});
  endtask

  task automatic test_short_b;
    rst_req_n = 1'b0;
    repeat (3) @(posedge clk_b);
    en_b = 1'b0;
    wait_a(20);
    offset_sel = 2'b11;
    #1;
    rst_req_n = 1'b1;
    wait_a(10);
    en_b = 1'b1;
    wait_b(10);
    check("R5 done_a/incomplete", {2'b0, done_a, rst_incomplete}, 4'b0001);
    check("R5 done_b", {3'b0, done_b}, 4'b0000);
    check("R5 full_n", {3'b0, init_full_n}, 4'b0000);
  endtask

  task automatic test_short_a;
    rst_req_n = 1'b0;
    repeat (3) @(posedge clk_a);
    en_a = 1'b0;
    wait_b(20);
    #1;
    rst_req_n = 1'b1;
    wait_b(10);
    en_a = 1'b1;
    wait_a(10);
    check("R6 done_a/done_b/incomplete", {1'b0, done_a, done_b, rst_incomplete}, 4'b0001);
    check_flags("R6");
  endtask

  task automatic test_recover;
    rst_req_n = 1'b0;
    wait_a(20);
    wait_b(4);
    check("R8 incomplete cleared", {3'b0, rst_incomplete}, 4'b0000);
    test_good_release(2'b01);
    check("R8 completes", {2'b0, done_a, rst_incomplete}, 4'b0010);
  endtask

  initial begin
    test_hold_state;
    test_good_release(2'b10);
    test_hold_state;
    test_good_release(2'b11);
    test_short_b;
    test_recover;
    test_short_a;
    test_recover;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule